// File: doc/BRIEF.md
# Register-Write Command Coalescer

The coalescer takes a stream of register write requests, each an offset, a 32-bit value and a 32-bit byte mask, and packs them into a command buffer of dword-sized entries. The buffer is internal RAM. An ordinary request becomes a two-dword single-write instruction. When the same register receives another full-word write straight after, the block merges the two. It rewrites the earlier single write in place into a counted burst, then appends each further value to that burst. The buffer stays compact for long runs of writes to one data port.

A finish command closes the buffer. It zero-fills up to the next line boundary, and the command stream can then be handed to an executor. When a request would not fit, the block raises a one-cycle overflow error and drops the request. A read port lets the owner inspect the packed contents. The fill position output shows how far the buffer is used.

Top module: `regwr_coalescer`

## Requirements
- R1: After reset the fill position is 0, `req_ready` is high and `err_overflow` is low.
- R2: A request that does not merge starts a new instruction at the fill position rounded up to an even dword. The start dword holds the value. The next dword holds 0x01 in bits [31:24], the byte enables in bits [23:20] and the offset, zero-extended, in bits [19:0]. The fill position becomes start+2.
- R3: Byte enable bit b (0..3) is set exactly when some bit of `req_mask[8b+7:8b]` is set.
- R4: A request merges only when four conditions hold together. Its mask is all ones. Its offset equals that of the last open instruction. That instruction is a single write with byte enables 4'hF, or a burst. Something has been emitted since reset or finish. Any other request starts a new instruction.
- R5: Merging into a single write at start s rewrites it in place. Dword s becomes the count. Dword s+1 becomes 0x09 in bits [31:24], zero in [23:20] and the offset in [19:0]. Dword s+2 becomes the earlier value. The new value goes to s+3, the count ends at 2 and the fill position at s+4.
- R6: Merging into a burst writes the value at the fill position and advances it by one. The count at the burst's start dword then goes up by one.
- R7: If the fill position is odd after a value is appended to a burst, the dword at the fill position is zero.
- R8: Finish zero-fills from the fill position up to the next multiple of LINE_DW (16) dwords and moves the fill position there. It also closes the last instruction, so the next request never merges.
- R9: A request accepted while the fill position exceeds DEPTH_DW-2 is dropped. `err_overflow` is high for exactly the following cycle, and the buffer and the fill position stay as they were.
- R10: `req_ready` is low for this many cycles after the accepting edge: 2 for a new instruction, 2 for a burst append (3 with a pad), 5 for a conversion, 0 for a dropped request, and one per zero-filled dword for finish.
- R11: When `req_valid` and `fin_valid` are both high in an accepting cycle, the request is served and that finish is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_offset | input | OFS_W | Register offset |
| req_data | input | 32 | Register value |
| req_mask | input | 32 | Bit mask, reduced to byte enables |
| fin_valid | input | 1 | Finish command, taken when ready and no request |
| err_overflow | output | 1 | One-cycle pulse: request dropped for lack of room |
| fill_pos | output | clog2(DEPTH_DW+1) | Current fill position in dwords |
| rd_addr | input | clog2(DEPTH_DW) | Buffer read address |
| rd_data | output | 32 | Buffer read data, one cycle after the address |

## Verification
The overflow pulse appears at the first falling edge after the accepting rising edge, and it is sampled there. The ready signal stays low for a count of cycles fixed by R10. The bench counts falling edges with ready low until it returns, and compares that count with the count computed for each kind of request. Buffer words read back one cycle after the address is presented, and are read only while the block is idle. Every written word is checked against an arithmetic model after each request and each finish.

// File: rtl/coal_pkg.sv
package coal_pkg;
   localparam int WORD_W    = 32;
   localparam int BE_W      = WORD_W / 8;
   localparam int OFS_FLD_W = 20;

   localparam logic [7:0] OPC_SINGLE = 8'h01;
   localparam logic [7:0] OPC_BURST  = 8'h09;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [3:0] {
      S_IDLE,
      S_NEW_VAL,
      S_NEW_HDR,
      S_CV_CNT,
      S_CV_HDR,
      S_CV_PREV,
      S_AP_VAL,
      S_AP_CNT,
      S_AP_PAD,
      S_FILL
   } seq_state_e;

   typedef enum logic [1:0] {
      K_NONE,
      K_SINGLE_FULL,
      K_SINGLE_PART,
      K_BURST
   } last_kind_e;
endpackage

// File: rtl/coal_byte_en.sv
module coal_byte_en
   import coal_pkg::*;
#(
   parameter int LANES = BE_W
) (
   input  logic [LANES*8-1:0] mask,
   output logic [LANES-1:0]   be
);
   for (genvar b = 0; b < LANES; b++) begin : g_lane
      assign be[b] = |mask[8*b +: 8];
   end
endmodule

// File: rtl/coal_hdr_fmt.sv
module coal_hdr_fmt
   import coal_pkg::*;
#(
   parameter int OFS_W = 20
) (
   input  logic             burst,
   input  logic [BE_W-1:0]  be,
   input  logic [OFS_W-1:0] ofs,
   output word_t            hdr
);
   logic [OFS_FLD_W-1:0] ofs_ext;

   assign ofs_ext = OFS_FLD_W'(ofs);
   assign hdr     = burst ? {OPC_BURST, {BE_W{1'b0}}, ofs_ext}
                          : {OPC_SINGLE, be, ofs_ext};
endmodule

// File: rtl/coal_buf.sv
module coal_buf
   import coal_pkg::*;
#(
   parameter int DEPTH_DW = 64,
   localparam int AW      = $clog2(DEPTH_DW)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  word_t         wr_data,
   input  logic [AW-1:0] rd_addr,
   output word_t         rd_data
);
   word_t mem [DEPTH_DW];
   word_t rd_q;

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
      rd_q <= mem[rd_addr];
   end

   assign rd_data = rd_q;
endmodule

// File: rtl/coal_seq.sv
module coal_seq
   import coal_pkg::*;
#(
   parameter int DEPTH_DW = 64,
   parameter int LINE_DW  = 16,
   parameter int OFS_W    = 20,
   localparam int AW      = $clog2(DEPTH_DW),
   localparam int PW      = $clog2(DEPTH_DW + 1),
   localparam int LB      = $clog2(LINE_DW)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [OFS_W-1:0] req_ofs,
   input  word_t            req_value,
   input  logic [BE_W-1:0]  req_be,
   input  logic             req_full,
   input  logic             fin_valid,
   output logic             req_ready,
   output logic             err_overflow,
   output logic [PW-1:0]    fill_pos,
   output logic             wr_en,
   output logic [AW-1:0]    wr_addr,
   output word_t            wr_data
);
   localparam logic [PW-1:0] ROOM_LIM = PW'(DEPTH_DW - 2);

   seq_state_e       st;
   last_kind_e       lkind;
   logic [PW-1:0]    fill_q, start_q, cnt_q;
   logic [OFS_W-1:0] lofs, r_ofs;
   word_t            lval, r_val;
   logic [BE_W-1:0]  r_be;
   logic             err_q;

   logic [PW-1:0]    even_up, fill_inc, wpos;
   logic             no_room, can_merge;
   word_t            hdr_w;

   assign even_up   = fill_q + PW'(fill_q[0]);
   assign fill_inc  = fill_q + PW'(1);
   assign no_room   = fill_q > ROOM_LIM;
   assign can_merge = (lkind == K_SINGLE_FULL || lkind == K_BURST)
                      && req_full && (lofs == req_ofs);

   coal_hdr_fmt #(.OFS_W(OFS_W)) u_hdr (
      .burst (st == S_CV_HDR),
      .be    (r_be),
      .ofs   (r_ofs),
      .hdr   (hdr_w)
   );

   always_comb begin
      wr_en   = 1'b1;
      wpos    = fill_q;
      wr_data = '0;
      unique case (st)
         S_NEW_VAL: begin wpos = start_q;            wr_data = r_val;              end
         S_NEW_HDR: begin wpos = start_q + PW'(1);   wr_data = hdr_w;              end
         S_CV_CNT:  begin wpos = start_q;            wr_data = WORD_W'(1);         end
         S_CV_HDR:  begin wpos = start_q + PW'(1);   wr_data = hdr_w;              end
         S_CV_PREV: begin wpos = start_q + PW'(2);   wr_data = lval;               end
         S_AP_VAL:  begin wpos = fill_q;             wr_data = r_val;              end
         S_AP_CNT:  begin wpos = start_q;            wr_data = WORD_W'(cnt_q);     end
         S_AP_PAD:  begin wpos = fill_q;             wr_data = '0;                 end
         S_FILL:    begin wpos = fill_q;             wr_data = '0;                 end
         default:   begin wr_en = 1'b0;                                            end
      endcase
   end

   assign wr_addr = wpos[AW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= S_IDLE;
         lkind   <= K_NONE;
         fill_q  <= '0;
         start_q <= '0;
         cnt_q   <= '0;
         lofs    <= '0;
         lval    <= '0;
         r_ofs   <= '0;
         r_val   <= '0;
         r_be    <= '0;
         err_q   <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (st)
            S_IDLE: begin
               if (req_valid) begin
                  if (no_room) begin
                     err_q <= 1'b1;
                  end else begin
                     r_val <= req_value;
                     r_ofs <= req_ofs;
                     r_be  <= req_be;
                     if (can_merge) begin
                        st <= (lkind == K_BURST) ? S_AP_VAL : S_CV_CNT;
                     end else begin
                        start_q <= even_up;
                        st      <= S_NEW_VAL;
                     end
                  end
               end else if (fin_valid) begin
                  lkind <= K_NONE;
                  if (fill_q[LB-1:0] != '0) st <= S_FILL;
               end
            end
            S_NEW_VAL: st <= S_NEW_HDR;
            S_NEW_HDR: begin
               fill_q <= start_q + PW'(2);
               lkind  <= (r_be == '1) ? K_SINGLE_FULL : K_SINGLE_PART;
               lofs   <= r_ofs;
               lval   <= r_val;
               st     <= S_IDLE;
            end
            S_CV_CNT: st <= S_CV_HDR;
            S_CV_HDR: st <= S_CV_PREV;
            S_CV_PREV: begin
               fill_q <= start_q + PW'(3);
               cnt_q  <= PW'(1);
               lkind  <= K_BURST;
               st     <= S_AP_VAL;
            end
            S_AP_VAL: begin
               fill_q <= fill_inc;
               cnt_q  <= cnt_q + PW'(1);
               st     <= S_AP_CNT;
            end
            S_AP_CNT: st <= fill_q[0] ? S_AP_PAD : S_IDLE;
            S_AP_PAD: st <= S_IDLE;
            S_FILL: begin
               fill_q <= fill_inc;
               if (fill_inc[LB-1:0] == '0) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign req_ready    = (st == S_IDLE);
   assign err_overflow = err_q;
   assign fill_pos     = fill_q;
endmodule

// File: rtl/regwr_coalescer.sv
module regwr_coalescer
   import coal_pkg::*;
#(
   parameter int DEPTH_DW = 64,
   parameter int LINE_DW  = 16,
   parameter int OFS_W    = 20
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   output logic                            req_ready,
   input  logic [OFS_W-1:0]                req_offset,
   input  logic [31:0]                     req_data,
   input  logic [31:0]                     req_mask,
   input  logic                            fin_valid,
   output logic                            err_overflow,
   output logic [$clog2(DEPTH_DW+1)-1:0]   fill_pos,
   input  logic [$clog2(DEPTH_DW)-1:0]     rd_addr,
   output logic [31:0]                     rd_data
);
   localparam int AW = $clog2(DEPTH_DW);
   localparam int PW = $clog2(DEPTH_DW + 1);
   localparam int LB = $clog2(LINE_DW);

   if (OFS_W < 1 || OFS_W > OFS_FLD_W) begin : g_bad_ofs
      $error("OFS_W must be 1..20");
   end
   if (LINE_DW < 2 || (1 << LB) != LINE_DW) begin : g_bad_line
      $error("LINE_DW must be a power of two of at least 2");
   end
   if (DEPTH_DW < LINE_DW || (DEPTH_DW % LINE_DW) != 0) begin : g_bad_depth
      $error("DEPTH_DW must be a nonzero multiple of LINE_DW");
   end

   logic [BE_W-1:0] be;
   logic            wr_en;
   logic [AW-1:0]   wr_addr;
   word_t           wr_data;
   logic [PW-1:0]   fill_w;

   coal_byte_en #(.LANES(BE_W)) u_be (
      .mask (req_mask),
      .be   (be)
   );

   coal_seq #(
      .DEPTH_DW (DEPTH_DW),
      .LINE_DW  (LINE_DW),
      .OFS_W    (OFS_W)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .req_valid    (req_valid),
      .req_ofs      (req_offset),
      .req_value    (req_data),
      .req_be       (be),
      .req_full     (&req_mask),
      .fin_valid    (fin_valid),
      .req_ready    (req_ready),
      .err_overflow (err_overflow),
      .fill_pos     (fill_w),
      .wr_en        (wr_en),
      .wr_addr      (wr_addr),
      .wr_data      (wr_data)
   );

   coal_buf #(.DEPTH_DW(DEPTH_DW)) u_buf (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data)
   );

   assign fill_pos = fill_w;
endmodule

// File: rtl/coal_chk.sv
module coal_chk #(
   parameter int DEPTH_DW = 64,
   parameter int LINE_DW  = 16,
   localparam int PW      = $clog2(DEPTH_DW + 1),
   localparam int LB      = $clog2(LINE_DW)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          req_ready,
   input logic          fin_valid,
   input logic          err_overflow,
   input logic [PW-1:0] fill_pos
);
   localparam logic [PW-1:0] LIM = PW'(DEPTH_DW - 2);

   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && fill_pos > LIM) |=> (err_overflow && req_ready));

   // R9
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |-> $past(req_valid && req_ready && fill_pos > LIM));

   // R9
   err_keep_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_overflow |-> fill_pos == $past(fill_pos));

   // R10
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && fill_pos <= LIM) |=> !req_ready);

   // R8
   fill_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_valid && !req_valid && req_ready && fill_pos[LB-1:0] != '0) |=> !req_ready);

   // R8
   fill_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_pos >= $past(fill_pos));

   // R9
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fill_pos <= PW'(DEPTH_DW));
endmodule

bind regwr_coalescer coal_chk #(.DEPTH_DW(DEPTH_DW), .LINE_DW(LINE_DW)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_valid    (req_valid),
   .req_ready    (req_ready),
   .fin_valid    (fin_valid),
   .err_overflow (err_overflow),
   .fill_pos     (fill_pos)
);

// File: tb/regwr_coalescer_tb_top.sv
module regwr_coalescer_tb_top;
   localparam int DEPTH = 64;
   localparam int LINE  = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [19:0] req_offset = '0;
   logic [31:0] req_data = '0;
   logic [31:0] req_mask = '0;
   logic        fin_valid = 1'b0;
   logic        err_overflow;
   logic [6:0]  fill_pos;
   logic [5:0]  rd_addr = '0;
   logic [31:0] rd_data;

   int n_chk = 0;
   int n_err = 0;

   logic [31:0] mm [DEPTH];
   int mfill, mstart, mkind, mcnt;
   logic [19:0] mofs;
   logic [31:0] mval;

   always #4 clk = ~clk;

   regwr_coalescer #(.DEPTH_DW(DEPTH), .LINE_DW(LINE), .OFS_W(20)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_offset(req_offset), .req_data(req_data), .req_mask(req_mask),
      .fin_valid(fin_valid), .err_overflow(err_overflow), .fill_pos(fill_pos),
      .rd_addr(rd_addr), .rd_data(rd_data)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < DEPTH; i++) mm[i] = '0;
      mfill = 0; mstart = 0; mkind = 0; mcnt = 0; mofs = '0; mval = '0;
      @(negedge clk);
      // R1 reset state
      chk(fill_pos == 0, "R1 fill", 32'(fill_pos), 0);
      chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
      chk(err_overflow == 1'b0, "R1 err", 32'(err_overflow), 0);
   endtask

   task automatic check_buf(input string tag);
      chk(fill_pos == 7'(mfill), {tag, " fill"}, 32'(fill_pos), 32'(mfill));
      for (int i = 0; i < mfill; i++) begin
         @(negedge clk);
         rd_addr = 6'(i);
         @(negedge clk);
         chk(rd_data == mm[i], {tag, " word"}, rd_data, mm[i]);
      end
   endtask

   // model derived from R2..R9
   task automatic model_req(input logic [19:0] ofs, input logic [31:0] val, input logic [31:0] mask,
                            output bit e_err, output int e_busy);
      logic [3:0] be;
      bit full;
      e_err = 0; e_busy = 0;
      if (mfill > DEPTH - 2) begin
         e_err = 1;
         return;
      end
      for (int b = 0; b < 4; b++) be[b] = (mask[8*b +: 8] != 0);
      full = (mask == 32'hFFFF_FFFF);
      if (mkind != 0 && full && mofs == ofs && (mkind == 1 || mkind == 3)) begin
         if (mkind == 1) begin
            mm[mstart]     = 1;
            mm[mstart + 1] = {8'h09, 4'h0, ofs};
            mm[mstart + 2] = mval;
            mfill = mstart + 3;
            mcnt = 1;
            mkind = 3;
            e_busy = 3;
         end
         mm[mfill] = val;
         mfill++;
         mcnt++;
         mm[mstart] = mcnt;
         e_busy += 2;
         if (mfill % 2 == 1) begin
            mm[mfill] = 0;
            e_busy++;
         end
      end else begin
         mstart = mfill + (mfill % 2);
         mm[mstart]     = val;
         mm[mstart + 1] = {8'h01, be, ofs};
         mfill = mstart + 2;
         mkind = (be == 4'hF) ? 1 : 2;
         mofs = ofs;
         mval = val;
         e_busy = 2;
      end
   endtask

   task automatic do_req(input logic [19:0] ofs, input logic [31:0] val, input logic [31:0] mask,
                         input bit with_fin, input string tag);
      bit e_err;
      int e_busy;
      int busy;
      model_req(ofs, val, mask, e_err, e_busy);
      @(negedge clk);
      req_valid = 1'b1; req_offset = ofs; req_data = val; req_mask = mask;
      fin_valid = with_fin;
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      fin_valid = 1'b0;
      chk(err_overflow == e_err, {tag, " R9 err"}, 32'(err_overflow), 32'(e_err));
      busy = 0;
      while (!req_ready && busy < 100) begin
         busy++;
         @(negedge clk);
      end
      chk(busy == e_busy, {tag, " R10 busy"}, 32'(busy), 32'(e_busy));
      check_buf(tag);
   endtask

   task automatic do_fin(input string tag);
      int e_busy;
      int busy;
      e_busy = (LINE - (mfill % LINE)) % LINE;
      for (int i = mfill; i < mfill + e_busy; i++) mm[i] = 0;
      mfill += e_busy;
      mkind = 0;
      @(negedge clk);
      fin_valid = 1'b1;
      @(negedge clk);
      fin_valid = 1'b0;
      busy = 0;
      while (!req_ready && busy < 100) begin
         busy++;
         @(negedge clk);
      end
      chk(busy == e_busy, {tag, " R10 busy"}, 32'(busy), 32'(e_busy));
      check_buf(tag);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [31:0] m;
      // phase A: merge and conversion
      do_reset();
      do_req(20'h00100, 32'hA000_0001, 32'hFFFF_FFFF, 0, "R2 first single");
      do_req(20'h00100, 32'hA000_0002, 32'hFFFF_FFFF, 0, "R5 convert");
      do_req(20'h00100, 32'hA000_0003, 32'hFFFF_FFFF, 0, "R6 R7 append pad");
      do_req(20'h00200, 32'hB000_0001, 32'h0101_0101, 0, "R2 R3 align after pad");
      do_req(20'h00200, 32'hB000_0002, 32'hFFFF_FFFF, 0, "R4 merge into BE F");
      do_req(20'h00300, 32'hC000_0001, 32'h0000_FF00, 0, "R3 partial");
      do_req(20'h00300, 32'hC000_0002, 32'hFFFF_FFFF, 0, "R4 no merge partial");
      do_req(20'h00400, 32'hD000_0001, 32'hFFFF_FFFF, 0, "R4 other offset");
      do_req(20'h00400, 32'hD000_0002, 32'hFFFF_FFFF, 0, "R5 convert again");
      do_fin("R8 finish fill");
      do_req(20'h00400, 32'hD000_0003, 32'hFFFF_FFFF, 0, "R8 closed no merge");

      // phase B: every byte-enable pattern, same offset, no merges
      do_reset();
      for (int p = 0; p < 16; p++) begin
         m = '0;
         for (int b = 0; b < 4; b++)
            if (p[b]) m |= (32'h1 << ((p + b) % 8)) << (8 * b);
         do_req(20'h00055, 32'h5000_0000 + 32'(p), m, 0, "R3 R4 mask sweep");
      end
      do_fin("R8 aligned finish");

      // R11 priority of request over finish
      do_reset();
      do_req(20'h00077, 32'h7700_0001, 32'hFFFF_FFFF, 1, "R11 req over finish");
      do_req(20'h00077, 32'h7700_0002, 32'hFFFF_FFFF, 0, "R11 still open");

      // phase C: fill with singles then overflow
      do_reset();
      for (int k = 0; k < 34; k++)
         do_req(20'(k + 16), 32'hC0DE_0000 + 32'(k), 32'hFFFF_FFFF, 0, "R9 singles");

      // phase D: one long burst to an odd full buffer
      do_reset();
      for (int k = 0; k < 63; k++)
         do_req(20'h00009, 32'hE000_0000 + 32'(k), 32'hFFFF_FFFF, 0, "R6 R7 R9 burst");

      summary();
      $finish;
   end
endmodule